// File: doc/BRIEF.md
# SPI Byte Transceiver for a CPU Bus

This block lets a processor exchange single bytes with an SD/MMC card running in SPI mode 0. The processor writes a byte to the data register, and that write starts a transfer. The block then produces eight serial clock pulses. It sends the byte out most significant bit first and collects the eight bits that the card returns. When the transfer has finished, a read of the same data register returns the received byte. A status register shows whether a transfer is still running. A control register holds the chip-select level, which the processor sets and clears itself, so that a multi-byte card command stays framed between its first and last byte.

The block runs from the processor bus clock. The serial clock toggles on every bus cycle, so it runs at half the bus rate, and a full byte takes sixteen bus cycles. Bit 7 of the written byte goes onto the serial output on the cycle after the write. Only the remaining bits are held for shifting. The same shift register takes in the received bits as the transmit bits leave it.

Top module: `spi_byte_xcvr`

## Requirements
- R1: After reset, `spi_sclk` is 0, `spi_cs_n` is 1 (deselected), `spi_mosi` is 1 and the status busy bit reads 0.
- R2: A bus write to address 0 while idle sets busy on the next clock edge. After that edge `spi_mosi` equals bit 7 of the written byte and `spi_sclk` is still 0.
- R3: During a transfer `spi_sclk` inverts on every clock edge. It gives eight high phases over the sixteen edges that follow the starting write. After the sixteenth edge, busy is 0 and `spi_sclk` is 0.
- R4: `spi_mosi` presents the written byte most significant bit first. It changes only on the edges where `spi_sclk` falls, and each bit stays in place for two cycles.
- R5: `spi_miso` is sampled on each edge where `spi_sclk` rises. The first sample becomes bit 7 of the received byte. After the transfer, a read of address 0 returns the eight received bits.
- R6: A write to address 0 while busy is ignored. The running transfer keeps its outgoing bit sequence, and the received byte is unchanged.
- R7: A read of address 1 returns the busy flag in bit 0 and zeros in the other bits.
- R8: A write to address 2 sets the chip-select enable from data bit 0, where 1 drives `spi_cs_n` low. The change appears one edge later. Writes to this register take effect even while a transfer is running, and transfers never alter it.
- R9: On the edge that ends a transfer, `spi_mosi` returns to 1 and stays 1 while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Register window selected this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register select: 0 data, 1 status, 2 control |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the card |
| spi_miso | input | 1 | Serial data from the card |
| spi_cs_n | output | 1 | Card select, active low |

## Verification
If the bit counter is wrong, the transfer ends with the wrong number of serial clock pulses. That shows at once in the edge index where busy drops and the serial clock stops. A wrong shift register shows up in two ways. The outgoing bit on the first falling edge after the write is wrong, and the byte read back sixteen cycles later is wrong. Each transfer checks every cycle of the serial clock and data lines against a timeline that the bench computes itself. A bad value is therefore caught in the cycle where it first appears, not only at the final read.

// File: rtl/spi_xcvr_pkg.sv
package spi_xcvr_pkg;

   // Register window decode; the data slot must stay at 0 since it is the
   // location that both launches a transfer and returns the received byte.
   typedef enum logic [1:0] {
      SEL_DATA = 2'd0,
      SEL_STAT = 2'd1,
      SEL_CTRL = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;

   localparam int unsigned STAT_BUSY_BIT = 0;
   localparam int unsigned CTRL_CS_BIT   = 0;

endpackage

// File: rtl/spi_xcvr_regs.sv
module spi_xcvr_regs
   import spi_xcvr_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              bus_we,
   input  logic [1:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              busy,
   input  logic [DATA_W-1:0] rx_data,
   output logic              start,
   output logic              cs_active,
   output logic [DATA_W-1:0] rdata
);

   reg_sel_e sel;
   logic     wr_any;
   logic     cs_wr;
   logic     cs_q;

   assign sel    = reg_sel_e'(bus_addr);
   assign wr_any = bus_en & bus_we;
   assign cs_wr  = wr_any & (sel == SEL_CTRL);

   // a data write during a running transfer is dropped here
   assign start  = wr_any & (sel == SEL_DATA) & ~busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cs_q <= 1'b0;
      end else if (cs_wr) begin
         cs_q <= bus_wdata[CTRL_CS_BIT];
      end
   end

   assign cs_active = cs_q;

   always_comb begin
      rdata = '0;
      unique case (sel)
         SEL_DATA: rdata = rx_data;
         SEL_STAT: rdata[STAT_BUSY_BIT] = busy;
         SEL_CTRL: rdata[CTRL_CS_BIT] = cs_q;
         default:  rdata = '0;
      endcase
   end

   // chip select moves only through its own register write
   assert_cs_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_wr |=> $stable(cs_q));

   // no launch while a transfer is running
   assert_no_start_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !start);

endmodule

// File: rtl/spi_xcvr_engine.sv
module spi_xcvr_engine #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] start_data,
   input  logic              miso,
   output logic              sclk,
   output logic              mosi,
   output logic              busy,
   output logic [DATA_W-1:0] rx_data
);

   localparam int unsigned CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

   // Top bit is never loaded from the bus: the transmit MSB goes straight
   // to mosi_q, so only DATA_W-1 transmit bits are stored.
   logic [DATA_W-1:0] sr_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              sclk_q;
   logic              mosi_q;
   logic              busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sr_q   <= '0;
         cnt_q  <= '0;
         sclk_q <= 1'b0;
         mosi_q <= 1'b1;
         busy_q <= 1'b0;
      end else if (start) begin
         busy_q                <= 1'b1;
         sclk_q                <= 1'b0;
         cnt_q                 <= '0;
         mosi_q                <= start_data[DATA_W-1];
         sr_q[DATA_W-2:0]      <= start_data[DATA_W-2:0];
      end else if (busy_q) begin
         if (!sclk_q) begin
            sclk_q <= 1'b1;
            sr_q   <= {sr_q[DATA_W-2:0], miso};
         end else begin
            sclk_q <= 1'b0;
            if (cnt_q == LAST_BIT) begin
               busy_q <= 1'b0;
               mosi_q <= 1'b1;
               cnt_q  <= '0;
            end else begin
               cnt_q  <= cnt_q + 1'b1;
               mosi_q <= sr_q[DATA_W-1];
            end
         end
      end
   end

   assign sclk    = sclk_q;
   assign mosi    = mosi_q;
   assign busy    = busy_q;
   assign rx_data = sr_q;

   assert_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (busy_q && !sclk_q));

   assert_sclk_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> !sclk_q);

   assert_mosi_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sclk_q) |-> $stable(mosi_q));

   assert_idle_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> mosi_q);

endmodule

// File: rtl/spi_byte_xcvr.sv
module spi_byte_xcvr #(
   parameter int unsigned DATA_W        = 8,
   parameter bit          CS_ACTIVE_LOW = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              bus_we,
   input  logic [1:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              spi_sclk,
   output logic              spi_mosi,
   input  logic              spi_miso,
   output logic              spi_cs_n
);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("DATA_W must be at least 2");
      end
      if ((DATA_W & (DATA_W - 1)) != 0) begin : g_bad_pow2
         $error("DATA_W must be a power of two");
      end
   endgenerate

   logic              start;
   logic              busy;
   logic              cs_active;
   logic [DATA_W-1:0] rx_data;

   spi_xcvr_regs #(.DATA_W(DATA_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_en    (bus_en),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .busy      (busy),
      .rx_data   (rx_data),
      .start     (start),
      .cs_active (cs_active),
      .rdata     (bus_rdata)
   );

   spi_xcvr_engine #(.DATA_W(DATA_W)) u_engine (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .start_data (bus_wdata),
      .miso       (spi_miso),
      .sclk       (spi_sclk),
      .mosi       (spi_mosi),
      .busy       (busy),
      .rx_data    (rx_data)
   );

   generate
      if (CS_ACTIVE_LOW) begin : g_cs_low
         assign spi_cs_n = ~cs_active;
      end else begin : g_cs_high
         assign spi_cs_n = cs_active;
      end
   endgenerate

endmodule

// File: tb/spi_byte_xcvr_bench.sv
module spi_byte_xcvr_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_en = 1'b0;
   logic       bus_we = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       spi_sclk;
   logic       spi_mosi;
   logic       spi_miso = 1'b1;
   logic       spi_cs_n;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   spi_byte_xcvr u_spi_byte_xcvr (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_en    (bus_en),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .spi_sclk  (spi_sclk),
      .spi_mosi  (spi_mosi),
      .spi_miso  (spi_miso),
      .spi_cs_n  (spi_cs_n)
   );

   // {transmit byte, byte the card returns}
   localparam logic [15:0] VEC [6] = '{
      16'hA5_3C, 16'h00_FF, 16'hFF_00, 16'h81_7E, 16'h5A_C3, 16'h01_80
   };

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic read_reg(input logic [1:0] a, output logic [7:0] v);
      bus_addr = a;
      bus_en   = 1'b1;
      bus_we   = 1'b0;
      #1;
      v = bus_rdata;
      bus_en = 1'b0;
   endtask

   task automatic write_reg(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_en = 1'b1; bus_we = 1'b1;
      @(negedge clk);
      bus_en = 1'b0; bus_we = 1'b0;
   endtask

   // full byte transfer with a per-cycle timeline check; optional mid-run
   // data write (ignored) and chip-select write
   task automatic xfer(input logic [7:0] tx, input logic [7:0] rx,
                       input bit poke_data, input bit poke_cs, input bit cs_val);
      logic [7:0] v;
      @(negedge clk);
      bus_addr = 2'd0; bus_wdata = tx; bus_en = 1'b1; bus_we = 1'b1;
      @(negedge clk);
      bus_en = 1'b0; bus_we = 1'b0;
      read_reg(2'd1, v);
      chk("R2 busy after launch", v, 8'h01);
      chk("R2 first mosi", {7'd0, spi_mosi}, {7'd0, tx[7]});
      chk("R2 sclk low after launch", {7'd0, spi_sclk}, 8'h00);
      spi_miso = rx[7];
      for (int j = 1; j <= 16; j++) begin
         @(negedge clk);
         chk("R3 sclk phase", {7'd0, spi_sclk}, {7'd0, 1'(j % 2)});
         if (j < 16) begin
            chk("R4 mosi bit", {7'd0, spi_mosi}, {7'd0, tx[7 - j/2]});
            read_reg(2'd1, v);
            chk("R7 busy during transfer", v, 8'h01);
         end else begin
            chk("R9 mosi idle high", {7'd0, spi_mosi}, 8'h01);
            read_reg(2'd1, v);
            chk("R3 busy clear after 16 edges", v, 8'h00);
         end
         if (j % 2 == 0 && j < 16) spi_miso = rx[7 - j/2];
         if (j == 7 && poke_cs) chk("R8 cs during transfer", {7'd0, spi_cs_n}, {7'd0, ~cs_val});
         if (poke_data && j == 3) begin
            bus_addr = 2'd0; bus_wdata = ~tx; bus_en = 1'b1; bus_we = 1'b1;
         end else if (poke_cs && j == 6) begin
            bus_addr = 2'd2; bus_wdata = {7'd0, cs_val}; bus_en = 1'b1; bus_we = 1'b1;
         end else begin
            bus_en = 1'b0; bus_we = 1'b0;
         end
      end
      bus_en = 1'b0; bus_we = 1'b0;
      read_reg(2'd0, v);
      chk(poke_data ? "R6 rx after ignored write" : "R5 received byte", v, rx);
   endtask

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      chk("R1 sclk in reset", {7'd0, spi_sclk}, 8'h00);
      chk("R1 cs_n in reset", {7'd0, spi_cs_n}, 8'h01);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 mosi after reset", {7'd0, spi_mosi}, 8'h01);
      read_reg(2'd1, v);
      chk("R1 busy after reset", v, 8'h00);

      write_reg(2'd2, 8'h01);
      chk("R8 cs asserted", {7'd0, spi_cs_n}, 8'h00);
      read_reg(2'd2, v);
      chk("R8 cs readback", v, 8'h01);

      foreach (VEC[i]) xfer(VEC[i][15:8], VEC[i][7:0], 1'b0, 1'b0, 1'b0);

      chk("R8 cs kept across transfers", {7'd0, spi_cs_n}, 8'h00);

      // ignored data write mid-run, R6
      xfer(8'hC6, 8'h39, 1'b1, 1'b0, 1'b0);
      read_reg(2'd1, v);
      chk("R6 no second transfer", v, 8'h00);
      repeat (2) @(negedge clk);
      chk("R6 sclk stays idle", {7'd0, spi_sclk}, 8'h00);

      // chip select dropped mid-run, R8
      xfer(8'h3E, 8'hD4, 1'b0, 1'b1, 1'b0);
      chk("R8 cs released", {7'd0, spi_cs_n}, 8'h01);

      repeat (4) @(negedge clk);
      chk("R9 mosi idle", {7'd0, spi_mosi}, 8'h01);
      read_reg(2'd3, v);
      chk("R7 unused slot zero", v, 8'h00);

      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      #2000000;
      if (!done) begin
         done = 1'b1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule